// File: doc/BRIEF.md
# Multi-Bank Striping Write Steerer

This block lets a group of local SRAM banks, fixed and ordered at build time, be written as one logical target. A transfer is opened with a start pulse that carries a starting logical word offset and a partitioning mode. After that, a valid/ready stream of words arrives, and the block sends each accepted word to exactly one bank's write port. Each bank's local address is worked out from the logical position of that word.

There are two partitioning modes. In concatenated mode the group behaves as one long memory: the first bank fills up, then the next bank in list order. In interleaved mode consecutive words rotate across the banks, and the local address advances once per full rotation. A word whose logical position lies at or past the group's capacity (banks × depth) is accepted and discarded, and a sticky overflow flag is raised for the transfer. The word flagged last closes the transfer.

Control is a three-state machine. `ST_IDLE` waits for `start`. It moves to `ST_STREAM` when the offset lies inside the group, and to `ST_SPILL` when it does not. `ST_STREAM` writes each accepted word and stays in place. It moves to `ST_IDLE` on an accepted last word, and to `ST_SPILL` when a non-last word consumes the final slot of the group. `ST_SPILL` discards words until an accepted last word, then moves to `ST_IDLE`.

Top module: `stripe_steer`

## Requirements
- R1: During and directly after reset, every bank write enable is 0, `overflow` is 0 and `in_ready` is 0.
- R2: `in_ready` goes to 1 on the clock edge that samples `start` while idle. It returns to 0 on the edge that accepts a word with `in_last` = 1. A `start` pulse seen while a transfer is open has no effect on the mapping.
- R3: In concatenated mode (`start_mode` = 0), the first word goes to bank offset / DEPTH at local address offset % DEPTH.
- R4: In concatenated mode, each following word takes the next local address of the same bank. After address DEPTH-1 it continues at address 0 of the next bank in list order.
- R5: In interleaved mode (`start_mode` = 1), the first word goes to bank offset % NUM_BANKS at local address offset / NUM_BANKS.
- R6: In interleaved mode, each following word goes to the next bank. After the last bank it wraps to bank 0 with the local address increased by one.
- R7: Each accepted word yields a single-cycle write enable on exactly one bank, one cycle after acceptance, carrying that word's data. A cycle with no accepted word yields no write.
- R8: A word whose logical position (offset + word index) is at least NUM_BANKS × DEPTH produces no write. It sets `overflow` one cycle after acceptance. `overflow` stays at 1 until the next transfer starts, and it is cleared on that start. A transfer that ends exactly at capacity leaves `overflow` at 0.
- R9: A start offset at or past capacity discards every word of that transfer and raises `overflow`.
- R10: The mode is captured at start. Changes on `start_mode` during an open transfer do not alter the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a transfer when idle |
| start_off | input | OFF_W | Starting logical word offset |
| start_mode | input | 1 | 0 concatenated, 1 interleaved |
| in_valid | input | 1 | Input word valid |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Marks the final word of the transfer |
| in_ready | output | 1 | Transfer open, words accepted |
| wr_en | output | NUM_BANKS | Per-bank write enable |
| wr_addr | output | NUM_BANKS*ADDR_W | Per-bank local address, bank b at slice b |
| wr_data | output | NUM_BANKS*DATA_W | Per-bank write data, bank b at slice b |
| overflow | output | 1 | Sticky: a word of this transfer was discarded |

## Verification
The bench goes after the seams of both mappings.

- **Bank boundary in concatenated mode.** A steerer that forgot to move on would wrap the address inside the same bank.
- **Rotation end in interleaved mode.** A design that missed the address increment would overwrite the first row.
- **Stalls in the middle of a stream.** A design that advanced its cursor without a handshake would skip slots.
- **Transfers ending exactly at capacity and running past it.** An off-by-one here either drops the final legal word or writes bank 0 again after wrapping.
- **Start offset already out of range.** Handled the same way as running past capacity.
- **Start pulses and mode flips inside an open transfer.** A block that re-captured them would jump to a new bank or switch partitioning in the middle of a stream.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    typedef enum logic {
        MODE_CONCAT     = 1'b0,
        MODE_INTERLEAVE = 1'b1
    } stripe_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_SPILL  = 2'd2
    } steer_state_e;

endpackage

// File: rtl/stripe_origin.sv
// Maps a starting logical offset to the first bank and local address.
module stripe_origin
    import stripe_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_DEPTH = 8,
    parameter int OFF_W      = 6,
    parameter int BANK_W     = 2,
    parameter int ADDR_W     = 3
) (
    input  logic [OFF_W-1:0]  off,
    input  stripe_mode_e      mode,
    output logic [BANK_W-1:0] org_bank,
    output logic [ADDR_W-1:0] org_addr,
    output logic              beyond
);
    localparam logic [OFF_W-1:0] DEPTH_V = OFF_W'(BANK_DEPTH);
    localparam logic [OFF_W-1:0] BANKS_V = OFF_W'(NUM_BANKS);
    localparam logic [OFF_W-1:0] CAP_V   = OFF_W'(NUM_BANKS * BANK_DEPTH);

    always_comb begin
        beyond = (off >= CAP_V);
        unique case (mode)
            MODE_CONCAT: begin
                org_bank = BANK_W'(off / DEPTH_V);
                org_addr = ADDR_W'(off % DEPTH_V);
            end
            MODE_INTERLEAVE: begin
                org_bank = BANK_W'(off % BANKS_V);
                org_addr = ADDR_W'(off / BANKS_V);
            end
            default: begin
                org_bank = '0;
                org_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/stripe_advance.sv
// Computes the slot following the current one and flags the end of the group.
module stripe_advance
    import stripe_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_DEPTH = 8,
    parameter int BANK_W     = 2,
    parameter int ADDR_W     = 3
) (
    input  logic [BANK_W-1:0] cur_bank,
    input  logic [ADDR_W-1:0] cur_addr,
    input  stripe_mode_e      mode,
    output logic [BANK_W-1:0] adv_bank,
    output logic [ADDR_W-1:0] adv_addr,
    output logic              wrap
);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BANK_DEPTH - 1);

    always_comb begin
        adv_bank = cur_bank;
        adv_addr = cur_addr;
        wrap     = 1'b0;
        unique case (mode)
            MODE_CONCAT: begin
                if (cur_addr == LAST_ADDR) begin
                    adv_addr = '0;
                    if (cur_bank == LAST_BANK) begin
                        adv_bank = '0;
                        wrap     = 1'b1;
                    end else begin
                        adv_bank = cur_bank + BANK_W'(1);
                    end
                end else begin
                    adv_addr = cur_addr + ADDR_W'(1);
                end
            end
            MODE_INTERLEAVE: begin
                if (cur_bank == LAST_BANK) begin
                    adv_bank = '0;
                    if (cur_addr == LAST_ADDR) begin
                        adv_addr = '0;
                        wrap     = 1'b1;
                    end else begin
                        adv_addr = cur_addr + ADDR_W'(1);
                    end
                end else begin
                    adv_bank = cur_bank + BANK_W'(1);
                end
            end
            default: begin
                wrap = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/stripe_fsm.sv
// Transfer control: state, captured mode, slot cursor and overflow flag.
module stripe_fsm
    import stripe_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  stripe_mode_e      start_mode,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [BANK_W-1:0] org_bank,
    input  logic [ADDR_W-1:0] org_addr,
    input  logic              beyond,
    input  logic [BANK_W-1:0] adv_bank,
    input  logic [ADDR_W-1:0] adv_addr,
    input  logic              wrap,
    output steer_state_e      state_q,
    output stripe_mode_e      mode_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              in_ready,
    output logic              write_go,
    output logic              overflow
);
    steer_state_e state_d;
    logic         load;
    logic         drop;
    logic         accept;

    // next-state logic
    always_comb begin
        state_d = state_q;
        accept  = in_valid && (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = beyond ? ST_SPILL : ST_STREAM;
            end
            ST_STREAM: begin
                if (accept) begin
                    if (in_last)   state_d = ST_IDLE;
                    else if (wrap) state_d = ST_SPILL;
                end
            end
            ST_SPILL: begin
                if (accept && in_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        in_ready = 1'b0;
        load     = 1'b0;
        write_go = 1'b0;
        drop     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = start;
            end
            ST_STREAM: begin
                in_ready = 1'b1;
                write_go = in_valid;
            end
            ST_SPILL: begin
                in_ready = 1'b1;
                drop     = in_valid;
            end
            default: ;
        endcase
    end

    // cursor, captured mode and overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_CONCAT;
            bank_q   <= '0;
            addr_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (load) begin
                mode_q   <= start_mode;
                bank_q   <= org_bank;
                addr_q   <= org_addr;
                overflow <= 1'b0;
            end else begin
                if (write_go) begin
                    bank_q <= adv_bank;
                    addr_q <= adv_addr;
                end
                if (drop) overflow <= 1'b1;
            end
        end
    end

    // R10: the captured mode stays put while a transfer remains open
    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && $past(in_ready)) |-> $stable(mode_q));

endmodule

// File: rtl/stripe_wport.sv
// Registered write port of a single bank.
module stripe_wport #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= hit;
            if (hit) begin
                wr_addr <= addr_in;
                wr_data <= data_in;
            end
        end
    end
endmodule

// File: rtl/stripe_steer.sv
module stripe_steer
    import stripe_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_DEPTH = 8,
    parameter int DATA_W     = 16,
    localparam int CAP       = NUM_BANKS * BANK_DEPTH,
    localparam int OFF_W     = $clog2(CAP) + 1,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [OFF_W-1:0]            start_off,
    input  logic                        start_mode,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_last,
    output logic                        in_ready,
    output logic [NUM_BANKS-1:0]        wr_en,
    output logic [NUM_BANKS*ADDR_W-1:0] wr_addr,
    output logic [NUM_BANKS*DATA_W-1:0] wr_data,
    output logic                        overflow
);
    stripe_mode_e      mode_in;
    stripe_mode_e      mode_q;
    steer_state_e      state_q;
    logic [BANK_W-1:0] org_bank, adv_bank, bank_q;
    logic [ADDR_W-1:0] org_addr, adv_addr, addr_q;
    logic              beyond, wrap, write_go;

    assign mode_in = stripe_mode_e'(start_mode);

    stripe_origin #(
        .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH),
        .OFF_W(OFF_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
    ) origin_i (
        .off(start_off), .mode(mode_in),
        .org_bank(org_bank), .org_addr(org_addr), .beyond(beyond)
    );

    stripe_advance #(
        .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH),
        .BANK_W(BANK_W), .ADDR_W(ADDR_W)
    ) advance_i (
        .cur_bank(bank_q), .cur_addr(addr_q), .mode(mode_q),
        .adv_bank(adv_bank), .adv_addr(adv_addr), .wrap(wrap)
    );

    stripe_fsm #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(mode_in),
        .in_valid(in_valid), .in_last(in_last),
        .org_bank(org_bank), .org_addr(org_addr), .beyond(beyond),
        .adv_bank(adv_bank), .adv_addr(adv_addr), .wrap(wrap),
        .state_q(state_q), .mode_q(mode_q), .bank_q(bank_q), .addr_q(addr_q),
        .in_ready(in_ready), .write_go(write_go), .overflow(overflow)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = write_go && (bank_q == BANK_W'(b));
        stripe_wport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) port_i (
            .clk(clk), .rst_n(rst_n), .hit(hit),
            .addr_in(addr_q), .data_in(in_data),
            .wr_en(wr_en[b]),
            .wr_addr(wr_addr[b*ADDR_W +: ADDR_W]),
            .wr_data(wr_data[b*DATA_W +: DATA_W])
        );
    end

    // R7: at most one bank written per cycle
    assert_single_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R7: a write only follows an accepted word
    assert_write_follows_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> $past(in_valid && in_ready));

    // R2: accepting the last word closes the transfer
    assert_last_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R8: discarded words never reach a bank
    assert_drop_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPILL && in_valid) |=> (wr_en == '0));

    // R8: overflow holds until a new transfer starts
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(start && !in_ready)) |=> overflow);

endmodule

// File: tb/stripe_steer_tb_top.sv
`timescale 1ns/1ps
module stripe_steer_tb_top;
    localparam int NB   = 4;
    localparam int D    = 8;
    localparam int DW   = 16;
    localparam int AW   = 3;
    localparam int OW   = 6;
    localparam int CAP  = NB * D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [OW-1:0]     start_off = '0;
    logic              start_mode = 1'b0;
    logic              in_valid = 1'b0;
    logic [DW-1:0]     in_data = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic [NB-1:0]     wr_en;
    logic [NB*AW-1:0]  wr_addr;
    logic [NB*DW-1:0]  wr_data;
    logic              overflow;

    stripe_steer #(.NUM_BANKS(NB), .BANK_DEPTH(D), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off),
        .start_mode(start_mode), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .overflow(overflow)
    );

    always #10 clk = ~clk;

    int    n_vec  = 0;
    int    n_miss = 0;
    int    obs_wr = 0;
    int    word_seq = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // behavioural reference model
    bit          m_busy = 0;
    bit          m_mode = 0;
    int          m_off = 0;
    int          m_k = 0;
    logic [NB-1:0] e_wen = '0;
    logic [AW-1:0] e_addr [NB];
    logic [DW-1:0] e_data [NB];
    bit          e_ovf = 0;
    bit          e_rdy = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_k = 0; e_wen = '0; e_ovf = 0; e_rdy = 0;
        end else begin
            e_wen = '0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_off = int'(start_off); m_mode = start_mode;
                    m_k = 0; e_ovf = 0;
                end
            end else if (in_valid) begin
                int lg, bk, ad;
                lg = m_off + m_k;
                if (lg < CAP) begin
                    if (m_mode) begin bk = lg % NB; ad = lg / NB; end
                    else        begin bk = lg / D;  ad = lg % D;  end
                    e_wen[bk]  = 1'b1;
                    e_addr[bk] = AW'(ad);
                    e_data[bk] = in_data;
                end else begin
                    e_ovf = 1;
                end
                m_k++;
                if (in_last) m_busy = 0;
            end
            e_rdy = m_busy;
        end
    end

    task automatic miss(input string tag, input string what, input int act, input int exp);
        n_miss++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if (wr_en !== e_wen) miss(cur_tag, "wr_en", int'(wr_en), int'(e_wen));
            if (overflow !== e_ovf) miss(cur_tag, "overflow", int'(overflow), int'(e_ovf));
            if (in_ready !== e_rdy) miss(cur_tag, "in_ready", int'(in_ready), int'(e_rdy));
            for (int b = 0; b < NB; b++) begin
                if (wr_en[b]) obs_wr++;
                if (e_wen[b] && wr_en[b]) begin
                    if (wr_addr[b*AW +: AW] !== e_addr[b])
                        miss(cur_tag, "wr_addr", int'(wr_addr[b*AW +: AW]), int'(e_addr[b]));
                    if (wr_data[b*DW +: DW] !== e_data[b])
                        miss(cur_tag, "wr_data", int'(wr_data[b*DW +: DW]), int'(e_data[b]));
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) miss(tag, what, act, exp);
    endtask

    task automatic xfer(input int off, input bit mode, input int len,
                        input int gap, input bit poke);
        @(negedge clk);
        start = 1; start_off = OW'(off); start_mode = mode;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < len; i++) begin
            if (gap != 0 && (i % gap) == gap - 1) begin
                in_valid = 0; in_last = 0;
                @(negedge clk);
            end
            if (poke && i == 2) begin
                start = 1; start_mode = ~mode; start_off = OW'(1);
            end
            in_valid = 1; in_data = DW'(16'hA000 + word_seq); in_last = (i == len - 1);
            word_seq++;
            @(negedge clk);
            start = 0; start_mode = mode;
        end
        in_valid = 0; in_last = 0;
        @(negedge clk);
    endtask

    task automatic run(input string tag, input int off, input bit mode, input int len,
                       input int gap, input bit poke, input int exp_wr, input bit exp_ovf);
        int w0;
        cur_tag = tag;
        w0 = obs_wr;
        xfer(off, mode, len, gap, poke);
        chk((obs_wr - w0) == exp_wr, tag, "write count", obs_wr - w0, exp_wr);
        chk(overflow == exp_ovf, tag, "overflow after transfer", int'(overflow), int'(exp_ovf));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_en == '0 && overflow == 0 && in_ready == 0, "R1", "reset outputs",
            int'({wr_en, overflow, in_ready}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(wr_en == '0 && overflow == 0 && in_ready == 0, "R1", "outputs after reset",
            int'({wr_en, overflow, in_ready}), 0);

        run("R3",  13, 0, 1, 0, 0, 1, 0);     // bank 1 addr 5
        run("R4",   5, 0, 6, 0, 0, 6, 0);     // crosses bank 0 -> 1
        run("R5",  13, 1, 1, 0, 0, 1, 0);     // bank 1 addr 3
        run("R6",   6, 1, 9, 0, 0, 9, 0);     // rotation wraps twice
        run("R7",   3, 0, 7, 2, 0, 7, 0);     // stalls every other word
        run("R7",   9, 1, 7, 3, 0, 7, 0);
        run("R2",   2, 0, 6, 0, 1, 6, 0);     // start pulse mid-transfer
        run("R10", 20, 1, 6, 0, 1, 6, 0);     // mode flip mid-transfer
        run("R8",  28, 0, 8, 0, 0, 4, 1);     // four words past capacity
        @(negedge clk);
        chk(overflow == 1, "R8", "overflow held while idle", int'(overflow), 1);
        run("R8",   0, 0, 32, 0, 0, 32, 0);   // exact capacity, clears flag
        run("R8",  30, 1, 4, 0, 0, 2, 1);
        run("R8",   0, 1, 32, 0, 0, 32, 0);
        run("R9",  40, 0, 3, 0, 0, 0, 1);
        run("R9",  32, 1, 2, 1, 0, 0, 1);
        run("R8",  31, 0, 2, 0, 0, 1, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_miss++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule